// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order integer core built as a chain of five stages: instruction fetch, operand read, execute/branch, data-memory access and register store. A clocked staging register sits between each pair of stages, and all of them advance on the same edge. The core runs register-register add, register-immediate add, a conditional branch that tests one register against zero, and a load and a store that use a base register plus a signed displacement. It drives two separate memory ports, one for instructions and one for data.

The fetch latch holds register numbers, not register contents. Operand read swaps the source numbers for their values. Each instruction carries its own fetch address down the stage latches, so the branch target is formed in execute from that copy and not from the live program counter, which has already moved on. The core has no forwarding and no interlocks. A program must place a consumer at least four instruction slots after the instruction that produces its operand. A taken branch costs two cycles, because it discards the two younger instructions.

Top module: `pipe_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and invalidates every stage latch. In the first cycle after reset the fetch address is 0, and no store strobe is raised until an instruction reaches the memory stage.
- R2: The instruction word is laid out as follows. Bits [31:24] hold the opcode, [23:20] the destination, [19:16] the first source, [15:12] the second source and [11:0] a signed immediate. The opcodes are 0x01 add, 0x02 add-immediate, 0x03 branch-if-zero, 0x04 load and 0x05 store. Any other opcode value behaves as a no-op and changes no register and no memory word.
- R3: When no branch is taken, the fetch address grows by 4 every cycle.
- R4: Add writes first source + second source to the destination. Add-immediate writes first source + sign-extended immediate. Either write happens in the store stage.
- R5: Branch-if-zero tests the first source in execute. If the value is zero, the next fetch is at the branch's own address plus the sign-extended immediate (a byte offset, forward or backward). If it is nonzero, fetch continues in sequence.
- R6: A taken branch squashes the two instructions fetched after it, so neither one changes any register or memory word.
- R7: The effective address of a load or store is first source + sign-extended immediate. A store raises the data write strobe for one cycle, with the second source as write data. A load writes the data-memory read value, returned combinationally, to its destination.
- R8: A store fetched in cycle n raises its write strobe in cycle n+3. A register result can be read by the instruction fetched four slots after its producer.
- R9: Register 0 always reads as zero. Writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stage latches advance on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, returned in the same cycle |
| dmem_addr | output | 32 | Byte address of the load or store in the memory stage |
| dmem_we | output | 1 | Data write strobe, one cycle per store |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Data word at dmem_addr, returned in the same cycle |

## Verification
The hardest case to reach from the ports is a taken branch that has real, state-changing instructions right behind it. Those instructions must vanish, and the redirect must work from the branch's own carried address whether the offset points forward or backward. The directed program places two register-modifying adds directly after an unconditional branch. It also runs a counted backward loop that exits through a zero test. Seeded random programs then scatter forward branches on random registers among adds, loads and stores. The final register file, dumped to data memory by stores, is compared with an instruction-level model in the bench.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_ADD  = 8'h01;
   localparam logic [OPC_W-1:0] OPC_ADDI = 8'h02;
   localparam logic [OPC_W-1:0] OPC_BRZ  = 8'h03;
   localparam logic [OPC_W-1:0] OPC_LD   = 8'h04;
   localparam logic [OPC_W-1:0] OPC_ST   = 8'h05;

   typedef enum logic [2:0] {
      K_NOP,
      K_ADD,
      K_ADDI,
      K_BRZ,
      K_LD,
      K_ST
   } kind_t;

   function automatic kind_t classify(input logic [OPC_W-1:0] opc);
      case (opc)
         OPC_ADD:  return K_ADD;
         OPC_ADDI: return K_ADDI;
         OPC_BRZ:  return K_BRZ;
         OPC_LD:   return K_LD;
         OPC_ST:   return K_ST;
         default:  return K_NOP;
      endcase
   endfunction

   function automatic logic writes_reg(input kind_t k);
      return (k == K_ADD) || (k == K_ADDI) || (k == K_LD);
   endfunction

endpackage

// File: rtl/pipe_fetch.sv
module pipe_fetch
   import pipe_pkg::*;
#(
   parameter int  XLEN  = 32,
   parameter int  REG_W = 4,
   parameter int  IMM_W = 12,
   localparam int ILEN  = OPC_W + 3*REG_W + IMM_W
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             redirect,
   input  logic [XLEN-1:0]  target,
   input  logic [ILEN-1:0]  instr,
   output logic [XLEN-1:0]  pc,
   output logic             lat_v,
   output kind_t            lat_kind,
   output logic [REG_W-1:0] lat_rd,
   output logic [REG_W-1:0] lat_rs1,
   output logic [REG_W-1:0] lat_rs2,
   output logic [IMM_W-1:0] lat_imm,
   output logic [XLEN-1:0]  lat_pc
);
   localparam int RS2_LSB = IMM_W;
   localparam int RS1_LSB = IMM_W + REG_W;
   localparam int RD_LSB  = IMM_W + 2*REG_W;
   localparam int OPC_LSB = IMM_W + 3*REG_W;
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

   logic [XLEN-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         lat_v    <= 1'b0;
         lat_kind <= K_NOP;
      end else begin
         pc_q     <= redirect ? target : pc_q + PC_STEP;
         lat_v    <= !redirect;
         lat_kind <= redirect ? K_NOP : classify(instr[OPC_LSB +: OPC_W]);
      end
      lat_rd  <= instr[RD_LSB  +: REG_W];
      lat_rs1 <= instr[RS1_LSB +: REG_W];
      lat_rs2 <= instr[RS2_LSB +: REG_W];
      lat_imm <= instr[0 +: IMM_W];
      lat_pc  <= pc_q;
   end

   assign pc = pc_q;

   // R1: the cycle after reset fetches from address zero with an empty latch
   a_r1_cold_start: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!lat_v && pc_q == '0));

endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
   parameter int  XLEN    = 32,
   parameter int  NREG    = 16,
   parameter bit  ZERO_R0 = 1'b1,
   localparam int REG_W   = $clog2(NREG)
)(
   input  logic             clk,
   input  logic             we,
   input  logic [REG_W-1:0] waddr,
   input  logic [XLEN-1:0]  wdata,
   input  logic [REG_W-1:0] raddr_a,
   output logic [XLEN-1:0]  rdata_a,
   input  logic [REG_W-1:0] raddr_b,
   output logic [XLEN-1:0]  rdata_b
);
   logic [XLEN-1:0] cells [NREG];
   logic            wr_ok;

   generate
      if (ZERO_R0) begin : g_hard_zero
         assign wr_ok   = we && (waddr != '0);
         assign rdata_a = (raddr_a == '0) ? '0 : cells[raddr_a];
         assign rdata_b = (raddr_b == '0) ? '0 : cells[raddr_b];
      end else begin : g_plain
         assign wr_ok   = we;
         assign rdata_a = cells[raddr_a];
         assign rdata_b = cells[raddr_b];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) cells[waddr] <= wdata;
   end

endmodule

// File: rtl/pipe_exec.sv
module pipe_exec
   import pipe_pkg::*;
#(
   parameter int XLEN = 32
)(
   input  logic            valid,
   input  kind_t           kind,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [XLEN-1:0] ofs,
   input  logic [XLEN-1:0] ipc,
   output logic [XLEN-1:0] sum,
   output logic            taken,
   output logic [XLEN-1:0] target
);
   logic [XLEN-1:0] rhs;

   always_comb begin
      // register forms take the second operand slot, memory forms the displacement
      rhs    = (kind == K_ADD || kind == K_ADDI) ? opb : ofs;
      sum    = opa + rhs;
      taken  = valid && (kind == K_BRZ) && (opa == '0);
      target = ipc + ofs;
   end

endmodule

// File: rtl/pipe_core.sv
module pipe_core
   import pipe_pkg::*;
#(
   parameter int  XLEN    = 32,
   parameter int  NREG    = 16,
   parameter int  IMM_W   = 12,
   parameter bit  ZERO_R0 = 1'b1,
   localparam int REG_W   = $clog2(NREG),
   localparam int ILEN    = OPC_W + 3*REG_W + IMM_W
)(
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [ILEN-1:0] imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic            dmem_we,
   output logic [XLEN-1:0] dmem_wdata,
   input  logic [XLEN-1:0] dmem_rdata
);
   initial begin
      a_cfg_nreg: assert (NREG >= 2 && (1 << REG_W) == NREG)
         else $error("NREG must be a power of two of at least 2");
      a_cfg_imm: assert (IMM_W >= 3 && IMM_W < XLEN)
         else $error("IMM_W must be at least 3 and narrower than XLEN");
      a_cfg_xlen: assert (XLEN >= 8)
         else $error("XLEN must be at least 8");
   end

   // fetch -> operand-read latch
   logic             f_v;
   kind_t            f_kind;
   logic [REG_W-1:0] f_rd, f_rs1, f_rs2;
   logic [IMM_W-1:0] f_imm;
   logic [XLEN-1:0]  f_pc;

   // operand-read -> execute latch
   logic             ofx_v;
   kind_t            ofx_kind;
   logic [REG_W-1:0] ofx_rd;
   logic [XLEN-1:0]  ofx_a, ofx_b, ofx_imm, ofx_pc;

   // execute -> memory latch
   logic             exm_v;
   kind_t            exm_kind;
   logic [REG_W-1:0] exm_rd;
   logic [XLEN-1:0]  exm_res, exm_sdat;

   // memory -> store latch
   logic             mwb_v, mwb_wen;
   logic [REG_W-1:0] mwb_rd;
   logic [XLEN-1:0]  mwb_val;

   logic             br_taken;
   logic [XLEN-1:0]  br_target, ex_sum;
   logic [XLEN-1:0]  rs_a, rs_b, imm_x;

   pipe_fetch #(
      .XLEN  (XLEN),
      .REG_W (REG_W),
      .IMM_W (IMM_W)
   ) u_fetch (
      .clk      (clk),
      .rst      (rst),
      .redirect (br_taken),
      .target   (br_target),
      .instr    (imem_rdata),
      .pc       (imem_addr),
      .lat_v    (f_v),
      .lat_kind (f_kind),
      .lat_rd   (f_rd),
      .lat_rs1  (f_rs1),
      .lat_rs2  (f_rs2),
      .lat_imm  (f_imm),
      .lat_pc   (f_pc)
   );

   pipe_regfile #(
      .XLEN    (XLEN),
      .NREG    (NREG),
      .ZERO_R0 (ZERO_R0)
   ) u_rf (
      .clk     (clk),
      .we      (mwb_wen),
      .waddr   (mwb_rd),
      .wdata   (mwb_val),
      .raddr_a (f_rs1),
      .rdata_a (rs_a),
      .raddr_b (f_rs2),
      .rdata_b (rs_b)
   );

   assign imm_x = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

   // operand read: source numbers become values, the immediate rides in the
   // second-operand slot for the add-immediate form
   always_ff @(posedge clk) begin
      if (rst) begin
         ofx_v    <= 1'b0;
         ofx_kind <= K_NOP;
      end else begin
         ofx_v    <= f_v && !br_taken;
         ofx_kind <= f_kind;
      end
      ofx_rd  <= f_rd;
      ofx_a   <= rs_a;
      ofx_b   <= (f_kind == K_ADDI) ? imm_x : rs_b;
      ofx_imm <= imm_x;
      ofx_pc  <= f_pc;
   end

   pipe_exec #(
      .XLEN (XLEN)
   ) u_ex (
      .valid  (ofx_v),
      .kind   (ofx_kind),
      .opa    (ofx_a),
      .opb    (ofx_b),
      .ofs    (ofx_imm),
      .ipc    (ofx_pc),
      .sum    (ex_sum),
      .taken  (br_taken),
      .target (br_target)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         exm_v    <= 1'b0;
         exm_kind <= K_NOP;
      end else begin
         exm_v    <= ofx_v;
         exm_kind <= ofx_kind;
      end
      exm_rd   <= ofx_rd;
      exm_res  <= ex_sum;
      exm_sdat <= ofx_b;
   end

   assign dmem_addr  = exm_res;
   assign dmem_wdata = exm_sdat;
   assign dmem_we    = exm_v && (exm_kind == K_ST);

   always_ff @(posedge clk) begin
      if (rst) begin
         mwb_v   <= 1'b0;
         mwb_wen <= 1'b0;
      end else begin
         mwb_v   <= exm_v;
         mwb_wen <= exm_v && writes_reg(exm_kind);
      end
      mwb_rd  <= exm_rd;
      mwb_val <= (exm_kind == K_LD) ? dmem_rdata : exm_res;
   end

   // R3: sequential fetch steps by one word
   a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
      !br_taken |=> imem_addr == $past(imem_addr) + XLEN'(4));

   // R5: a taken branch redirects to its own address plus offset
   a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
      br_taken |=> imem_addr == $past(ofx_pc + ofx_imm));

   // R6: both younger stages are empty right after a taken branch
   a_r6_squash: assert property (@(posedge clk) disable iff (rst)
      br_taken |=> (!f_v && !ofx_v));

   // R8: the memory and store stages advance in lock step
   a_r8_lockstep: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (mwb_v == $past(exm_v)));

   // R7: a store strobe never coincides with a register write from the same slot
   a_r7_store_no_wb: assert property (@(posedge clk) disable iff (rst)
      dmem_we |=> !mwb_wen);

endmodule

// File: tb/pipe_core_bench.sv
module pipe_core_bench;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] prog  [512];
   logic [31:0] dmem  [256];
   logic [31:0] m_reg [16];
   logic [31:0] m_mem [256];
   int plen;
   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   pipe_core u_pipe_core (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_we    (dmem_we),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_rdata = prog[imem_addr[10:2]];
   assign dmem_rdata = dmem[dmem_addr[9:2]];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
   end

   localparam logic [7:0] O_ADD = 8'h01, O_ADDI = 8'h02, O_BRZ = 8'h03,
                          O_LD = 8'h04, O_ST = 8'h05;

   function automatic logic [31:0] enc(logic [7:0] op, int rd, int ra, int rb, int imm);
      logic [31:0] iv;
      iv = 32'(imm);
      return {op, 4'(rd), 4'(ra), 4'(rb), iv[11:0]};
   endfunction

   task automatic emit(input logic [31:0] w);
      prog[plen] = w;
      plen++;
   endtask

   task automatic emit_sp(input logic [31:0] w);
      emit(w);
      repeat (3) emit(32'h0);
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // instruction-level model of the requirements
   task automatic iss_run();
      int pc;
      pc = 0;
      for (int s = 0; s < 20000; s++) begin
         logic [31:0] w, sx;
         logic [7:0]  op;
         int rd, ra, rb;
         w  = prog[(pc / 4) % 512];
         op = w[31:24];
         rd = int'(w[23:20]);
         ra = int'(w[19:16]);
         rb = int'(w[15:12]);
         sx = {{20{w[11]}}, w[11:0]};
         if (op == O_BRZ) begin
            if (ra == 0 && w[11:0] == 12'd0) break;
            if (m_reg[ra] == 32'd0) begin
               pc = pc + int'(sx);
               continue;
            end
         end else if (op == O_ADD) begin
            m_reg[rd] = m_reg[ra] + m_reg[rb];
         end else if (op == O_ADDI) begin
            m_reg[rd] = m_reg[ra] + sx;
         end else if (op == O_LD) begin
            m_reg[rd] = m_mem[((m_reg[ra] + sx) >> 2) % 256];
         end else if (op == O_ST) begin
            m_mem[((m_reg[ra] + sx) >> 2) % 256] = m_reg[rb];
         end
         m_reg[0] = 32'd0;
         pc = pc + 4;
      end
   endtask

   task automatic prologue();
      plen = 0;
      for (int i = 0; i < 512; i++) prog[i] = 32'h0;
      for (int r = 1; r < 16; r++)
         emit_sp(enc(O_ADDI, r, 0, 0, int'($urandom_range(0, 4095)) - 2048));
   endtask

   task automatic epilogue();
      repeat (3) emit_sp(32'h0);
      for (int r = 0; r < 16; r++) emit_sp(enc(O_ST, 0, 0, r, 512 + 4*r));
      emit(enc(O_BRZ, 0, 0, 0, 0));
   endtask

   task automatic build_directed(output int first_st);
      int lp, bz, back;
      prologue();
      first_st = plen;
      emit_sp(enc(O_ST, 0, 0, 1, 8));
      emit_sp(enc(O_ADDI, 1, 0, 0, 5));
      emit_sp(enc(O_ADDI, 2, 0, 0, -3));
      emit_sp(enc(O_ADD, 3, 1, 2, 0));
      emit_sp(enc(O_ADDI, 0, 0, 0, 77));           // R9 write to r0
      emit_sp(enc(O_ADD, 0, 1, 1, 0));
      emit_sp(enc(O_ADDI, 7, 0, 0, 64));
      emit_sp(enc(O_ST, 0, 7, 3, -8));              // R7 negative displacement
      emit_sp(enc(O_LD, 4, 7, 0, -8));
      emit_sp(enc(8'hFF, 6, 1, 2, 1));              // R2 unknown opcode
      emit(enc(O_BRZ, 0, 0, 0, 12));                // R6 squash two slots
      emit(enc(O_ADDI, 11, 11, 0, 100));
      emit(enc(O_ADDI, 12, 12, 0, 100));
      emit_sp(enc(O_BRZ, 0, 1, 0, 400));            // R5 not taken, r1 = 5
      emit_sp(enc(O_ADDI, 10, 10, 0, 1));
      emit_sp(enc(O_ADDI, 8, 0, 0, 3));
      emit_sp(enc(O_ADDI, 9, 0, 0, 0));
      lp = plen;
      emit_sp(enc(O_ADDI, 9, 9, 0, 1));
      emit_sp(enc(O_ADDI, 8, 8, 0, -1));
      bz = plen;
      emit_sp(32'h0);
      back = plen;
      emit_sp(enc(O_BRZ, 0, 0, 0, (lp - back) * 4)); // R5 backward
      prog[bz] = enc(O_BRZ, 0, 8, 0, (plen - bz) * 4);
      epilogue();
   endtask

   task automatic build_random();
      prologue();
      for (int i = 0; i < 30; i++) begin
         int kind;
         kind = int'($urandom_range(0, 4));
         case (kind)
            0: emit_sp(enc(O_ADD, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                           int'($urandom_range(0, 15)), 0));
            1: emit_sp(enc(O_ADDI, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), 0,
                           int'($urandom_range(0, 4095)) - 2048));
            2: emit_sp(enc(O_LD, int'($urandom_range(0, 15)), 0, 0,
                           4 * int'($urandom_range(0, 127))));
            3: emit_sp(enc(O_ST, 0, 0, int'($urandom_range(0, 15)),
                           4 * int'($urandom_range(0, 127))));
            default: emit_sp(enc(O_BRZ, 0, int'($urandom_range(0, 15)) % 4, 0,
                                 16 * int'($urandom_range(1, 3))));
         endcase
      end
      epilogue();
   endtask

   task automatic run_one(input string tag, input bit directed);
      int first_st, first_we, ncyc;
      rst = 1'b1;
      @(posedge clk);
      first_st = -1;
      if (directed) build_directed(first_st);
      else build_random();
      for (int i = 0; i < 256; i++) begin
         dmem[i]  = $urandom;
         m_mem[i] = dmem[i];
      end
      for (int r = 0; r < 16; r++) m_reg[r] = 32'd0;
      iss_run();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      first_we = -1;
      ncyc = plen * 3 + 60;
      for (int c = 0; c < ncyc; c++) begin
         #1;
         if (c == 0) begin
            chk("R1", "fetch address after reset", imem_addr, 32'd0);
            chk("R1", "store strobe after reset", {31'd0, dmem_we}, 32'd0);
         end else if (c < 5) begin
            chk("R3", "sequential fetch address", imem_addr, 32'(4 * c));
         end
         if (dmem_we && first_we < 0) first_we = c;
         @(negedge clk);
      end
      if (directed)
         chk("R8", "cycle of first store strobe", 32'(first_we), 32'(first_st + 3));
      for (int r = 0; r < 16; r++)
         chk((r == 0) ? "R9" : "R2/R4/R5/R6/R8", $sformatf("%s reg r%0d", tag, r),
             dmem[128 + r], m_reg[r]);
      for (int i = 0; i < 128; i++)
         chk("R7", $sformatf("%s data word %0d", tag, i), dmem[i], m_mem[i]);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      run_one("directed", 1'b1);
      for (int k = 0; k < 3; k++) run_one($sformatf("random%0d", k), 1'b0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule